// File: doc/BRIEF.md
# Fabric Master Adapter with Throughput Counters

This block sits between a master core and a shared on-chip communication fabric. The core hands it one transaction: a start address, a word count and a direction. The adapter then raises a request on the fabric. The request carries the address, which also selects the target slave in a flat address map, together with the number of words still wanted and the direction bit. The fabric answers with a grant that states how many words may move now. That grant is also the signal to start. The adapter moves that many words, one per cycle. If the grant did not cover the whole transaction, it requests the remainder at the advanced address. This repeats until every word has moved, and the adapter then pulses a completion flag.

Next to the transfer logic, three saturating counters record the words moved, the cycles spent waiting for grants and the cycles spent transmitting. Software or a test harness can divide the sum of the two cycle counts by the word count to obtain the average number of cycles per word that the fabric delivered. A synchronous clear input resets all three counters.

Top module: `fabric_master_adapter`

## Requirements
- R1: `cmd_ready` is high exactly when the adapter is idle. In that state a high `cmd_valid` captures `cmd_addr`, `cmd_len` and `cmd_read` (1 = read, 0 = write). For a non-zero length, `fab_req` rises in the next cycle with `fab_addr` = address, `fab_nword` = length and `fab_rnw` = direction. A `cmd_valid` seen while the adapter is busy has no effect.
- R2: While `fab_req` is high and no grant has arrived, the request stays high and `fab_addr`, `fab_nword` and `fab_rnw` hold steady.
- R3: A grant is a cycle in which `fab_req` and `fab_gnt_valid` are both high. The granted chunk is `fab_gnt_size` when that value lies between 1 and the remaining count. Otherwise the chunk is the remaining count: this covers a size of zero and any size larger than what remains.
- R4: In the cycle after a grant, `fab_beat` goes high for exactly one cycle per granted word, back to back, with `fab_req` low. On writes, `fab_wdata` equals `core_wdata` and `core_wtake` is high. On reads, `core_rvalid` is high and `core_rdata` equals `fab_rdata`.
- R5: `fab_addr` advances by one on every beat. If words remain after a chunk, `fab_req` rises in the next cycle with `fab_addr` equal to the start address plus the words already moved, and `fab_nword` equal to the remaining count.
- R6: `done` is a one-cycle pulse in the cycle after the final beat. A zero-length command raises `done` in the cycle after acceptance and issues no request.
- R7: `stat_wait` adds one for every cycle in which `fab_req` is high, including the grant cycle.
- R8: `stat_tx` and `stat_words` each add one for every beat cycle.
- R9: Each counter stops at its all-ones value (2^CW − 1) and does not wrap.
- R10: When `clr_stats` is high, all three counters read zero in the next cycle. The clear wins over an increment in the same cycle.
- R11: After reset the adapter is idle, `fab_req`, `fab_beat` and `done` are low, and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Core offers a transaction |
| cmd_ready | output | 1 | Adapter idle, command will be taken |
| cmd_addr | input | AW | Start word address |
| cmd_len | input | LW | Number of words |
| cmd_read | input | 1 | 1 = read, 0 = write |
| done | output | 1 | One-cycle completion pulse |
| core_wdata | input | DW | Write word from the core |
| core_wtake | output | 1 | Current write word consumed |
| core_rdata | output | DW | Read word to the core |
| core_rvalid | output | 1 | Read word valid |
| fab_req | output | 1 | Request to fabric |
| fab_addr | output | AW | Request / current word address |
| fab_nword | output | LW | Words still wanted |
| fab_rnw | output | 1 | Direction on fabric, 1 = read |
| fab_gnt_valid | input | 1 | Grant present |
| fab_gnt_size | input | LW | Words granted |
| fab_beat | output | 1 | A word moves this cycle |
| fab_wdata | output | DW | Write data to fabric |
| fab_rdata | input | DW | Read data from fabric |
| clr_stats | input | 1 | Synchronous counter clear |
| stat_words | output | CW | Words moved |
| stat_wait | output | CW | Cycles waiting for grants |
| stat_tx | output | CW | Cycles transmitting |

## Verification
The counter clear and a counter increment can land in the same cycle. The bench provokes this by raising `clr_stats` exactly on the third beat of a six-word single-grant transfer. The result is judged correct only if the word and transmit counts afterwards equal the three beats that follow the clear, and the wait count is zero. In a second case, the bench lets the counters run into saturation while transfers continue. It checks that they pin at 255 with CW = 8, and that a later clear still returns them to zero. The bench sweeps every length from 1 to 15 against every grant size from 0 to 15. This covers the zero-size and oversize clamps, and the split requests whose addresses and remaining counts the fabric model checks.

// File: rtl/fma_pkg.sv
package fma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } fma_state_e;

    localparam int CNT_WAIT = 0;
    localparam int CNT_TX   = 1;
    localparam int CNT_WORD = 2;
    localparam int NUM_CNT  = 3;

endpackage

// File: rtl/fma_satcnt.sv
module fma_satcnt #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/fma_ctrl.sv
module fma_ctrl
    import fma_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_addr,
    input  logic [LW-1:0] cmd_len,
    input  logic          cmd_read,
    input  logic          gnt_valid,
    input  logic [LW-1:0] gnt_size,
    output logic          idle_o,
    output logic          req_o,
    output logic          beat_o,
    output logic [AW-1:0] addr_o,
    output logic [LW-1:0] nword_o,
    output logic          rnw_o,
    output logic          done_o
);
    fma_state_e    state;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q;
    logic [LW-1:0] beats_q;
    logic          rnw_q;
    logic          done_q;

    function automatic logic [LW-1:0] clamp_grant(input logic [LW-1:0] g,
                                                  input logic [LW-1:0] r);
        return (g == '0 || g > r) ? r : g;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            beats_q <= '0;
            rnw_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        addr_q <= cmd_addr;
                        rem_q  <= cmd_len;
                        rnw_q  <= cmd_read;
                        if (cmd_len == '0) done_q <= 1'b1;
                        else               state  <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (gnt_valid) begin
                        beats_q <= clamp_grant(gnt_size, rem_q);
                        state   <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    addr_q  <= addr_q + 1'b1;
                    rem_q   <= rem_q - 1'b1;
                    beats_q <= beats_q - 1'b1;
                    if (rem_q == LW'(1)) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else if (beats_q == LW'(1)) begin
                        state <= ST_REQ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idle_o  = (state == ST_IDLE);
    assign req_o   = (state == ST_REQ);
    assign beat_o  = (state == ST_XFER);
    assign addr_o  = addr_q;
    assign nword_o = rem_q;
    assign rnw_o   = rnw_q;
    assign done_o  = done_q;

endmodule

// File: rtl/fabric_master_adapter.sv
module fabric_master_adapter
    import fma_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 8,
    parameter int DW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_addr,
    input  logic [LW-1:0] cmd_len,
    input  logic          cmd_read,
    output logic          done,
    input  logic [DW-1:0] core_wdata,
    output logic          core_wtake,
    output logic [DW-1:0] core_rdata,
    output logic          core_rvalid,
    output logic          fab_req,
    output logic [AW-1:0] fab_addr,
    output logic [LW-1:0] fab_nword,
    output logic          fab_rnw,
    input  logic          fab_gnt_valid,
    input  logic [LW-1:0] fab_gnt_size,
    output logic          fab_beat,
    output logic [DW-1:0] fab_wdata,
    input  logic [DW-1:0] fab_rdata,
    input  logic          clr_stats,
    output logic [CW-1:0] stat_words,
    output logic [CW-1:0] stat_wait,
    output logic [CW-1:0] stat_tx
);
    logic               wr_beat;
    logic               rd_beat;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CW-1:0]      cnt_val [NUM_CNT];

    fma_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .cmd_read  (cmd_read),
        .gnt_valid (fab_gnt_valid),
        .gnt_size  (fab_gnt_size),
        .idle_o    (cmd_ready),
        .req_o     (fab_req),
        .beat_o    (fab_beat),
        .addr_o    (fab_addr),
        .nword_o   (fab_nword),
        .rnw_o     (fab_rnw),
        .done_o    (done)
    );

    assign wr_beat     = fab_beat && !fab_rnw;
    assign rd_beat     = fab_beat &&  fab_rnw;
    assign core_wtake  = wr_beat;
    assign core_rvalid = rd_beat;
    assign fab_wdata   = wr_beat ? core_wdata : '0;
    assign core_rdata  = rd_beat ? fab_rdata  : '0;

    assign cnt_inc[CNT_WAIT] = fab_req;
    assign cnt_inc[CNT_TX]   = fab_beat;
    assign cnt_inc[CNT_WORD] = fab_beat;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        fma_satcnt #(.CW(CW)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (clr_stats),
            .inc   (cnt_inc[i]),
            .count (cnt_val[i])
        );
    end

    assign stat_wait  = cnt_val[CNT_WAIT];
    assign stat_tx    = cnt_val[CNT_TX];
    assign stat_words = cnt_val[CNT_WORD];

endmodule

// File: rtl/fma_checker.sv
module fma_checker #(
    parameter int AW = 32,
    parameter int LW = 8,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_ready,
    input logic          done,
    input logic          fab_req,
    input logic [AW-1:0] fab_addr,
    input logic [LW-1:0] fab_nword,
    input logic          fab_rnw,
    input logic          fab_gnt_valid,
    input logic          fab_beat,
    input logic          clr_stats,
    input logic [CW-1:0] stat_words,
    input logic [CW-1:0] stat_wait,
    input logic [CW-1:0] stat_tx
);
    localparam logic [CW-1:0] CMAX = '1;

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (fab_req || fab_beat) |-> !cmd_ready); // R1

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        fab_req && !fab_gnt_valid |=> fab_req && $stable(fab_addr)
            && $stable(fab_nword) && $stable(fab_rnw)); // R2

    AST_GRANT_TO_BEAT: assert property (@(posedge clk) disable iff (rst)
        fab_req && fab_gnt_valid |=> fab_beat && !fab_req); // R4

    AST_REQ_BEAT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fab_req && fab_beat)); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        fab_beat |=> fab_addr == AW'($past(fab_addr) + 1'b1)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_WAIT_COUNT: assert property (@(posedge clk) disable iff (rst)
        !clr_stats && fab_req && stat_wait != CMAX
            |=> stat_wait == CW'($past(stat_wait) + 1'b1)); // R7

    AST_TX_COUNT: assert property (@(posedge clk) disable iff (rst)
        !clr_stats && fab_beat && stat_tx != CMAX
            |=> stat_tx == CW'($past(stat_tx) + 1'b1)); // R8

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !clr_stats && stat_words == CMAX |=> stat_words == CMAX); // R9

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_stats |=> stat_words == '0 && stat_wait == '0 && stat_tx == '0); // R10

endmodule

bind fabric_master_adapter fma_checker #(.AW(AW), .LW(LW), .CW(CW)) u_chk (.*);

// File: tb/fabric_master_adapter_test.sv
`timescale 1ns/1ps
module fabric_master_adapter_test;
    localparam int AW = 8;
    localparam int LW = 4;
    localparam int DW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          cmd_read = 1'b0;
    logic          done;
    logic [DW-1:0] core_wdata;
    logic          core_wtake;
    logic [DW-1:0] core_rdata;
    logic          core_rvalid;
    logic          fab_req;
    logic [AW-1:0] fab_addr;
    logic [LW-1:0] fab_nword;
    logic          fab_rnw;
    logic          fab_gnt_valid = 1'b0;
    logic [LW-1:0] fab_gnt_size = '0;
    logic          fab_beat;
    logic [DW-1:0] fab_wdata;
    logic [DW-1:0] fab_rdata;
    logic          clr_stats;
    logic          clr_task = 1'b0;
    logic          clr_fab = 1'b0;
    logic [CW-1:0] stat_words, stat_wait, stat_tx;

    int total = 0;
    int bad = 0;

    // fabric model state
    logic [AW-1:0] exp_addr = '0;
    logic [LW-1:0] exp_rem = '0;
    logic          rnw_cur = 1'b0;
    logic [LW-1:0] gsel = '0;
    int            dly = 0;
    int            wcnt = 0;
    int            widx = 0;
    int            beatcnt = 0;
    int            clr_at = 0;

    assign clr_stats  = clr_task | clr_fab;
    assign core_wdata = DW'(16'h3C00 + widx);
    assign fab_rdata  = DW'(16'h9100 + widx);

    always #4 clk = ~clk;

    fabric_master_adapter #(.AW(AW), .LW(LW), .DW(DW), .CW(CW)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_read(cmd_read), .done(done),
        .core_wdata(core_wdata), .core_wtake(core_wtake), .core_rdata(core_rdata),
        .core_rvalid(core_rvalid), .fab_req(fab_req), .fab_addr(fab_addr),
        .fab_nword(fab_nword), .fab_rnw(fab_rnw), .fab_gnt_valid(fab_gnt_valid),
        .fab_gnt_size(fab_gnt_size), .fab_beat(fab_beat), .fab_wdata(fab_wdata),
        .fab_rdata(fab_rdata), .clr_stats(clr_stats), .stat_words(stat_words),
        .stat_wait(stat_wait), .stat_tx(stat_tx)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // grant responder, driven away from the active edge
    always @(negedge clk) begin
        fab_gnt_valid = 1'b0;
        clr_fab = 1'b0;
        if (!rst && fab_req) begin
            if (wcnt == dly) begin
                chk(fab_addr == exp_addr, "R5 request address", int'(fab_addr), int'(exp_addr));
                chk(fab_nword == exp_rem, "R5 request remaining", int'(fab_nword), int'(exp_rem));
                chk(fab_rnw == rnw_cur, "R1 request direction", int'(fab_rnw), int'(rnw_cur));
                fab_gnt_valid = 1'b1;
                fab_gnt_size = gsel;
            end
            wcnt++;
        end else begin
            wcnt = 0;
        end
        if (!rst && fab_beat) begin
            chk(fab_addr == exp_addr, "R5 beat address", int'(fab_addr), int'(exp_addr));
            if (rnw_cur) begin
                chk(core_rvalid && !core_wtake && core_rdata == DW'(16'h9100 + widx),
                    "R4 read data", int'(core_rdata), 16'h9100 + widx);
            end else begin
                chk(core_wtake && !core_rvalid && fab_wdata == DW'(16'h3C00 + widx),
                    "R4 write data", int'(fab_wdata), 16'h3C00 + widx);
            end
            exp_addr = exp_addr + 1'b1;
            exp_rem  = exp_rem - 1'b1;
            widx++;
            beatcnt++;
            if (beatcnt == clr_at) clr_fab = 1'b1;
        end
    end

    int sat_words = 0, sat_wait = 0, sat_tx = 0;

    function automatic int sat(input int v);
        return (v > 255) ? 255 : v;
    endfunction

    task automatic run_txn(input int addr, input int len, input bit rd, input int g,
                           input int d, input bit clear_first, input int clr_beat,
                           input bit poke);
        int nreq;
        int n;
        if (clear_first) begin
            @(negedge clk) clr_task = 1'b1;
            @(negedge clk) clr_task = 1'b0;
            sat_words = 0; sat_wait = 0; sat_tx = 0;
        end else begin
            @(negedge clk);
        end
        chk(cmd_ready == 1'b1, "R1 ready when idle", int'(cmd_ready), 1);
        exp_addr = AW'(addr); exp_rem = LW'(len); rnw_cur = rd;
        gsel = LW'(g); dly = d; widx = 0; beatcnt = 0; clr_at = clr_beat;
        cmd_addr = AW'(addr); cmd_len = LW'(len); cmd_read = rd; cmd_valid = 1'b1;
        nreq = (len == 0) ? 0 : ((g == 0 || g >= len) ? 1 : (len + g - 1) / g);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) cmd_valid = 1'b0;
            if (poke && n == 2) begin cmd_valid = 1'b1; cmd_len = 4'd5; cmd_read = ~rd; end
            if (poke && n == 3) cmd_valid = 1'b0;
        end while (!done && n < 400);
        chk(n == nreq * (d + 1) + len + 1, "R6 done latency", n, nreq * (d + 1) + len + 1);
        if (clr_beat != 0) begin
            chk(stat_words == CW'(len - clr_beat), "R10 words after clear", int'(stat_words), len - clr_beat);
            chk(stat_tx == CW'(len - clr_beat), "R10 tx after clear", int'(stat_tx), len - clr_beat);
            chk(stat_wait == '0, "R10 wait after clear", int'(stat_wait), 0);
        end else begin
            sat_words = sat(sat_words + len);
            sat_tx    = sat(sat_tx + len);
            sat_wait  = sat(sat_wait + nreq * (d + 1));
            chk(int'(stat_words) == sat_words, "R8 R9 words", int'(stat_words), sat_words);
            chk(int'(stat_tx) == sat_tx, "R8 R9 tx", int'(stat_tx), sat_tx);
            chk(int'(stat_wait) == sat_wait, "R7 R9 wait", int'(stat_wait), sat_wait);
        end
        @(negedge clk);
        chk(!done, "R6 done single pulse", int'(done), 0);
        chk(cmd_ready && !fab_req, "R1 idle after done", int'(fab_req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready && !fab_req && !fab_beat && !done, "R11 reset idle", int'(fab_req), 0);
        chk(stat_words == 0 && stat_wait == 0 && stat_tx == 0, "R11 reset counters",
            int'(stat_words), 0);

        // zero-length command: done next cycle, no request
        run_txn(8'h40, 0, 1'b0, 0, 0, 1'b1, 0, 1'b0);
        chk(stat_wait == 0, "R6 zero length no request", int'(stat_wait), 0);

        // busy command ignored (R1)
        run_txn(8'h10, 9, 1'b0, 4, 1, 1'b1, 0, 1'b1);
        run_txn(8'h20, 7, 1'b1, 3, 2, 1'b1, 0, 1'b1);

        // exhaustive sweep: lengths x grant sizes, incl. size 0 and oversize clamp (R3)
        for (int len = 1; len <= 15; len++) begin
            for (int g = 0; g <= 15; g++) begin
                run_txn((len * 16 + g) & 255, len, ((len + g) % 2) == 1, g, (len + g) % 3,
                        1'b1, 0, 1'b0);
            end
        end

        // clear in the same cycle as a beat increment (R10)
        run_txn(8'h05, 6, 1'b0, 0, 1, 1'b1, 3, 1'b0);

        // saturation without clearing (R9)
        run_txn(8'h80, 15, 1'b1, 0, 3, 1'b1, 0, 1'b0);
        for (int k = 0; k < 19; k++) begin
            run_txn(8'h80, 15, k[0], 0, 3, 1'b0, 0, 1'b0);
        end
        chk(stat_words == 8'hFF, "R9 words pinned", int'(stat_words), 255);
        chk(stat_wait == 8'd80, "R7 wait sum", int'(stat_wait), 80);
        @(negedge clk) clr_task = 1'b1;
        @(negedge clk) clr_task = 1'b0;
        chk(stat_words == 0 && stat_tx == 0 && stat_wait == 0, "R10 clear from saturation",
            int'(stat_words), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule